// File: doc/BRIEF.md
# Cumulative-Boundary Raster Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. It drives horizontal sync, vertical sync and data enable, the zero-based coordinates of the pixel being shown, and a one-cycle pulse at the first position of each frame. All of its outputs are registered. It runs on the pixel clock. Pixel fetch, blending and the clock pin driver are built elsewhere.

Timing is not programmed as separate sync, porch and active lengths. Four configuration words instead hold cumulative compare points, each minus one: the end of sync, the end of back porch, the end of the active area and the total. Each word carries the horizontal value in its upper half and the vertical value in its lower half. Each line and each frame runs sync, then back porch, then active area, then front porch. The front porch is whatever lies between the active boundary and the total.

A four-bit polarity word selects the active level of each output and carries a flag that tells the pixel-clock driver which edge to use. All five words are copied into shadow registers. The copy is taken at every cycle while the block is disabled, and otherwise only as the counters wrap to the start of a new frame, so a change made mid-frame never tears the picture.

Top module: `raster_timer`

## Requirements
- R1: With position counters (h, v), HSYNC is active while h is at most sync_cfg[31:16], and VSYNC is active while v is at most sync_cfg[15:0].
- R2: h counts from 0 to total_cfg[31:16] and then wraps to 0. v advances at each wrap of h and returns to 0 after reaching total_cfg[15:0].
- R3: DE is active only when h lies in the range from bporch_cfg[31:16] (exclusive) to active_cfg[31:16] (inclusive), and v lies in the range from bporch_cfg[15:0] (exclusive) to active_cfg[15:0] (inclusive).
- R4: While DE is active, x_o = h - bporch_cfg[31:16] - 1 and y_o = v - bporch_cfg[15:0] - 1. Both are 0 while DE is inactive.
- R5: With pol_cfg = 0, HSYNC and VSYNC are active low and DE is active high. Setting pol_cfg[0] makes HSYNC active high, pol_cfg[1] makes VSYNC active high, and pol_cfg[2] makes DE active low.
- R6: clk_fall_o presents pol_cfg[3], the request to change panel outputs on the falling clock edge.
- R7: While enabled, new configuration words take effect only for the first position of the frame that follows the current one (h = 0, v = 0).
- R8: While en is low, the counters hold at 0 and all outputs show their inactive levels. The first enabled cycle presents position (0, 0).
- R9: sof_o pulses for exactly the cycle that presents position (0, 0) while enabled.
- R10: During reset, HSYNC and VSYNC are high, DE, sof_o and clk_fall_o are low, and x_o and y_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; holds the counters at 0 while low |
| sync_cfg | input | 2*FW | Sync end minus one: horizontal in the upper half, vertical in the lower half |
| bporch_cfg | input | 2*FW | Accumulated back-porch end minus one, horizontal and vertical |
| active_cfg | input | 2*FW | Accumulated active end minus one, horizontal and vertical |
| total_cfg | input | 2*FW | Total minus one, horizontal and vertical |
| pol_cfg | input | 4 | Bit 0 HSYNC high, bit 1 VSYNC high, bit 2 DE low, bit 3 falling-edge flag |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | FW | Active column, zero-based |
| y_o | output | FW | Active row, zero-based |
| sof_o | output | 1 | Start-of-frame pulse |
| clk_fall_o | output | 1 | Falling-edge output flag |

## Verification
A wrong counter or shadow value shows up at the ports in the very next cycle. Each output register samples the counters and shadows directly, so a slipped count moves the sync edges, the DE window and the coordinates by one position at once. A shadow copied at the wrong time changes the line length or the polarity in the middle of a frame, and the bench catches that on the first position that differs. The bench follows the position and the active configuration cycle by cycle over several whole frames, across a mid-frame change of configuration and across a disable. It compares every output against arithmetic expectations at every position.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int FW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [2*FW-1:0] sync_cfg,
  input  logic [2*FW-1:0] bporch_cfg,
  input  logic [2*FW-1:0] active_cfg,
  input  logic [2*FW-1:0] total_cfg,
  input  logic [3:0]      pol_cfg,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [FW-1:0]   x_o,
  output logic [FW-1:0]   y_o,
  output logic            sof_o,
  output logic            clk_fall_o
);
  localparam int WW = 2 * FW;

  logic [WW-1:0] s_sync, s_bp, s_act, s_tot;
  logic [3:0]    s_pol;
  logic [FW-1:0] hcnt, vcnt;

  wire [FW-1:0] hsw  = s_sync[WW-1:FW];
  wire [FW-1:0] vsw  = s_sync[FW-1:0];
  wire [FW-1:0] ahbp = s_bp[WW-1:FW];
  wire [FW-1:0] avbp = s_bp[FW-1:0];
  wire [FW-1:0] aaw  = s_act[WW-1:FW];
  wire [FW-1:0] aah  = s_act[FW-1:0];
  wire [FW-1:0] tw   = s_tot[WW-1:FW];
  wire [FW-1:0] th   = s_tot[FW-1:0];

  wire line_end  = (hcnt == tw);
  wire frame_end = line_end && (vcnt == th);

  wire hs_act = en && (hcnt <= hsw);
  wire vs_act = en && (vcnt <= vsw);
  wire de_act = en && (hcnt > ahbp) && (hcnt <= aaw) && (vcnt > avbp) && (vcnt <= aah);
  wire at_org = en && (hcnt == '0) && (vcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sync <= '0;
      s_bp   <= '0;
      s_act  <= '0;
      s_tot  <= '0;
      s_pol  <= '0;
    end else if (!en || frame_end) begin
      s_sync <= sync_cfg;
      s_bp   <= bporch_cfg;
      s_act  <= active_cfg;
      s_tot  <= total_cfg;
      s_pol  <= pol_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o    <= 1'b1;
      vsync_o    <= 1'b1;
      de_o       <= 1'b0;
      x_o        <= '0;
      y_o        <= '0;
      sof_o      <= 1'b0;
      clk_fall_o <= 1'b0;
    end else begin
      hsync_o    <= ~(hs_act ^ s_pol[0]);
      vsync_o    <= ~(vs_act ^ s_pol[1]);
      de_o       <= de_act ^ s_pol[2];
      x_o        <= de_act ? hcnt - ahbp - 1'b1 : '0;
      y_o        <= de_act ? vcnt - avbp - 1'b1 : '0;
      sof_o      <= at_org;
      clk_fall_o <= s_pol[3];
    end
  end
endmodule

module raster_timer_chk #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          de_o,
  input logic          sof_o,
  input logic [FW-1:0] x_o,
  input logic [FW-1:0] y_o,
  input logic [FW-1:0] hcnt,
  input logic [FW-1:0] vcnt,
  input logic [FW-1:0] tw,
  input logic [FW-1:0] th,
  input logic [3:0]    s_pol,
  input logic [2*FW-1:0] s_tot
);
  a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= tw);

  a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hcnt != tw) |=> (hcnt == $past(hcnt) + 1'b1));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hcnt == '0 && vcnt == '0 && !sof_o));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(hcnt == tw && vcnt == th)) |=> $stable(s_tot));

  a_r4_xy_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (x_o != '0 || y_o != '0) |-> (de_o != $past(s_pol[2])));
endmodule

bind raster_timer raster_timer_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .de_o(de_o), .sof_o(sof_o),
  .x_o(x_o), .y_o(y_o), .hcnt(hcnt), .vcnt(vcnt), .tw(tw), .th(th),
  .s_pol(s_pol), .s_tot(s_tot)
);

// File: tb/sim_raster_timer.sv
`timescale 1ns/1ps
module sim_raster_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] sync_cfg, bporch_cfg, active_cfg, total_cfg;
  logic [3:0] pol_cfg;
  logic hsync_o, vsync_o, de_o, sof_o, clk_fall_o;
  logic [15:0] x_o, y_o;

  always #2 clk = ~clk;

  raster_timer u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sync_cfg(sync_cfg), .bporch_cfg(bporch_cfg), .active_cfg(active_cfg),
    .total_cfg(total_cfg), .pol_cfg(pol_cfg),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
    .sof_o(sof_o), .clk_fall_o(clk_fall_o)
  );

  typedef struct {
    int hs, vs, hb, vb, ha, va, ht, vt;
    logic [3:0] p;
  } cfg_t;

  cfg_t cur, act;
  int mh, mv;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R2";

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s phase %s pos h=%0d v=%0d actual=%0d expected=%0d",
               req, phase, mh, mv, got, exp);
    end
  endtask

  task automatic apply(input cfg_t c);
    cur = c;
    sync_cfg   = {16'(c.hs), 16'(c.vs)};
    bporch_cfg = {16'(c.hb), 16'(c.vb)};
    active_cfg = {16'(c.ha), 16'(c.va)};
    total_cfg  = {16'(c.ht), 16'(c.vt)};
    pol_cfg    = c.p;
  endtask

  task automatic step();
    bit ha, va, da, so;
    int ex, ey;
    @(negedge clk);
    ha = en && (mh <= act.hs);
    va = en && (mv <= act.vs);
    da = en && (mh > act.hb) && (mh <= act.ha) && (mv > act.vb) && (mv <= act.va);
    ex = da ? mh - act.hb - 1 : 0;
    ey = da ? mv - act.vb - 1 : 0;
    so = en && mh == 0 && mv == 0;
    chk("R1/R5 hsync", int'(hsync_o), int'(act.p[0] ? ha : !ha));
    chk("R1/R5 vsync", int'(vsync_o), int'(act.p[1] ? va : !va));
    chk("R3/R5 de", int'(de_o), int'(da ^ act.p[2]));
    chk("R4 x", int'(x_o), ex);
    chk("R4 y", int'(y_o), ey);
    chk("R9 sof", int'(sof_o), int'(so));
    chk("R6 clk_fall", int'(clk_fall_o), int'(act.p[3]));
    if (!en) begin
      act = cur; mh = 0; mv = 0;
    end else if (mh == act.ht) begin
      mh = 0;
      if (mv == act.vt) begin mv = 0; act = cur; end
      else mv++;
    end else mh++;
  endtask

  initial begin
    cfg_t ca, cb, cc;
    ca = '{hs:1, vs:0, hb:4, vb:2, ha:9, va:5, ht:11, vt:6, p:4'b0000};
    cb = '{hs:0, vs:1, hb:2, vb:3, ha:6, va:5, ht:8, vt:7, p:4'b1111};
    cc = '{hs:0, vs:0, hb:0, vb:0, ha:2, va:1, ht:3, vt:2, p:4'b0100};
    act = '{hs:0, vs:0, hb:0, vb:0, ha:0, va:0, ht:0, vt:0, p:4'b0000};
    mh = 0; mv = 0;
    apply(ca);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 hsync", int'(hsync_o), 1);
    chk("R10 vsync", int'(vsync_o), 1);
    chk("R10 de", int'(de_o), 0);
    chk("R10 xy", int'(x_o | y_o), 0);
    chk("R10 sof", int'(sof_o), 0);
    chk("R10 clk_fall", int'(clk_fall_o), 0);
    rst_n = 1'b1;
    phase = "R8";
    repeat (3) step();
    en = 1'b1;
    phase = "R2";
    repeat (2 * 84) step();
    repeat (30) step();
    apply(cb);
    phase = "R7";
    repeat (54 + 2 * 72) step();
    en = 1'b0;
    phase = "R8";
    repeat (4) step();
    apply(cc);
    repeat (2) step();
    en = 1'b1;
    repeat (40) step();
    en = 1'b0;
    repeat (3) step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule